// File: doc/BRIEF.md
# Graceful Transmit Stop Controller

This block decides when a frame transmitter may begin a new frame and when it has come to rest after software asks it to pause. Software holds a stop-request bit. If the transmitter is idle when the bit is set, the block halts at once. If a frame is on the wire, the block waits. It halts only when that frame ends normally, ends through a collision, or the busy indication drops. A frame is never cut short.

Halting is announced by a single-cycle completion interrupt. While a stop is pending or in force, the block grants no new frame start. A collision-terminated frame that the transmitter would normally retry is therefore held back as well. Clearing the stop bit returns the block to normal operation, and the next available frame may then start. If software withdraws the request before the halt is reached, the block returns to normal operation without raising the interrupt.

Top module: `gts_ctrl`

## Requirements
- R1: After synchronous reset the controller is in the running state and the completion interrupt is low.
- R2: In the running state, a set stop request with the busy input low moves the controller to the halted state at the next clock edge. The completion interrupt is high for exactly that first halted cycle.
- R3: In the running state, a set stop request with the busy input high moves the controller to the draining state. The controller stays in the draining state while busy remains high and neither end pulse arrives.
- R4: In the draining state with the stop request still set, any one of the following moves the controller to the halted state at the next edge, with a one-cycle completion interrupt: a frame-end pulse, a collision-abort pulse, or busy going low.
- R5: In the draining state, a cleared stop request returns the controller to the running state at the next edge. No completion interrupt is raised, even if an end pulse arrives in the same cycle.
- R6: In the halted state, a cleared stop request returns the controller to the running state at the next edge. No further interrupt is raised.
- R7: The start grant is high only when all four conditions hold: the state is running, the stop request is clear, a frame is ready, and busy is low. It is low throughout the draining and halted states, including after a collision abort.
- R8: The completion interrupt is never high for two consecutive cycles. It is high only in the first cycle of the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop-request register bit |
| tx_busy | input | 1 | A frame is currently being transmitted |
| frame_done | input | 1 | Pulse: current frame completed normally |
| coll_abort | input | 1 | Pulse: current frame terminated by collision |
| frame_ready | input | 1 | Another frame is available to send |
| tx_start_en | output | 1 | Permission to begin a new frame |
| stop_done_irq | output | 1 | One-cycle stop-complete interrupt |

## Verification
The assertions check several properties on every cycle: the start grant is never high outside the running state; the interrupt lasts one cycle and coincides only with the halted state; busy draining never ends without a termination event; and a withdrawn request always returns the controller to running. Some behaviours only the bench can show. These are the exact choice between the halted and draining states for each input combination, the priority of a withdrawn request over a same-cycle end pulse, and the absence of an interrupt on a withdrawn stop. The bench shows them by sweeping every input combination from each of the three states.

// File: rtl/gts_pkg.sv
package gts_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_HALTED = 2'd2
    } gts_state_t;

    typedef struct packed {
        logic stop;
        logic busy;
        logic ended;
        logic ready;
    } gts_in_t;

    function automatic gts_state_t gts_next(gts_state_t cur, gts_in_t in);
        gts_state_t nxt;
        nxt = cur;
        case (cur)
            ST_RUN: begin
                if (in.stop) nxt = in.busy ? ST_DRAIN : ST_HALTED;
            end
            ST_DRAIN: begin
                if (!in.stop) nxt = ST_RUN;
                else if (in.ended || !in.busy) nxt = ST_HALTED;
            end
            ST_HALTED: begin
                if (!in.stop) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gts_state_fsm.sv
module gts_state_fsm
    import gts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gts_in_t    in_bus,
    output gts_state_t state,
    output gts_state_t state_nxt
);
    assign state_nxt = gts_next(state, in_bus);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nxt;
    end

    // R3
    drain_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && in_bus.stop && in_bus.busy) |=> (state == ST_DRAIN));

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && in_bus.stop && in_bus.busy && !in_bus.ended)
        |=> (state == ST_DRAIN));

    // R5
    resume_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN && !in_bus.stop) |=> (state == ST_RUN));
endmodule

// File: rtl/gts_start_gate.sv
module gts_start_gate
    import gts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gts_state_t state,
    input  gts_in_t    in_bus,
    output logic       start_en
);
    assign start_en = (state == ST_RUN) && !in_bus.stop && in_bus.ready && !in_bus.busy;

    // R7
    no_grant_when_stopping_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> !start_en);
endmodule

// File: rtl/gts_done_pulse.sv
module gts_done_pulse
    import gts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gts_state_t state,
    input  gts_state_t state_nxt,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= (state_nxt == ST_HALTED) && (state != ST_HALTED);
    end

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8
    irq_in_halt_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (state == ST_HALTED));
endmodule

// File: rtl/gts_ctrl.sv
module gts_ctrl
    import gts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic tx_busy,
    input  logic frame_done,
    input  logic coll_abort,
    input  logic frame_ready,
    output logic tx_start_en,
    output logic stop_done_irq
);
    gts_in_t    in_bus;
    gts_state_t state;
    gts_state_t state_nxt;

    assign in_bus.stop  = stop_req;
    assign in_bus.busy  = tx_busy;
    assign in_bus.ended = frame_done | coll_abort;
    assign in_bus.ready = frame_ready;

    gts_state_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_bus    (in_bus),
        .state     (state),
        .state_nxt (state_nxt)
    );

    gts_start_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .in_bus   (in_bus),
        .start_en (tx_start_en)
    );

    gts_done_pulse u_pulse (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .state_nxt (state_nxt),
        .irq       (stop_done_irq)
    );

    // R4
    drain_to_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && stop_req && (frame_done || coll_abort)) |=> stop_done_irq);
endmodule

// File: tb/gts_ctrl_test.sv
`timescale 1ns/1ps
module gts_ctrl_test;
    logic clk = 1'b0;
    logic rst, stop_req, tx_busy, frame_done, coll_abort, frame_ready;
    logic tx_start_en, stop_done_irq;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gts_ctrl uut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .tx_busy(tx_busy),
        .frame_done(frame_done), .coll_abort(coll_abort),
        .frame_ready(frame_ready), .tx_start_en(tx_start_en),
        .stop_done_irq(stop_done_irq)
    );

    // bench-side state codes: 0 running, 1 draining, 2 halted
    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, b, d, c, r);
        @(negedge clk);
        stop_req = s; tx_busy = b; frame_done = d; coll_abort = c; frame_ready = r;
    endtask

    task automatic do_reset();
        drive(0, 0, 0, 0, 0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive to start state st, then leave inputs at negedge ready for the next drive
    task automatic goto_state(input int st);
        do_reset();
        if (st == 1) begin
            drive(1, 1, 0, 0, 0);   // R3 stop while busy
            @(posedge clk);
        end else if (st == 2) begin
            drive(1, 0, 0, 0, 0);   // R2 stop while idle
            @(posedge clk);
            #1 check("R2 idle stop irq", stop_done_irq, 1'b1);
        end
    endtask

    function automatic int model_next(int st, logic s, b, e);
        if (st == 0) return s ? (b ? 1 : 2) : 0;
        if (st == 1) return !s ? 0 : ((e || !b) ? 2 : 1);
        return s ? 2 : 0;
    endfunction

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        stop_req = 0; tx_busy = 0; frame_done = 0; coll_abort = 0; frame_ready = 0;
        do_reset();
        #1 check("R1 reset irq low", stop_done_irq, 1'b0);
        frame_ready = 1'b1;
        #0.1 check("R1 reset state running grants", tx_start_en, 1'b1);

        for (int st = 0; st < 3; st++) begin
            for (int combo = 0; combo < 32; combo++) begin
                logic s, b, d, c, r;
                int nxt;
                s = combo[4]; b = combo[3]; d = combo[2]; c = combo[1]; r = combo[0];
                goto_state(st);
                drive(s, b, d, c, r);
                #1 check("R7 grant in stimulus cycle", tx_start_en,
                         (st == 0) && !s && r && !b);
                nxt = model_next(st, s, b, d | c);
                @(posedge clk);
                #1 check(st == 1 && !s ? "R5 no irq on withdraw" :
                         st == 1 ? "R4 drain end irq" :
                         st == 2 ? "R6 no repeat irq" : "R2 R3 entry irq",
                         stop_done_irq, (nxt == 2) && (st != 2));
                // probe: observe whether state is running through the grant
                stop_req = 0; tx_busy = 0; frame_done = 0; coll_abort = 0; frame_ready = 1;
                #0.5 check(nxt == 0 ? "R6 resume grants" : "R7 blocked in stop",
                           tx_start_en, nxt == 0);
                @(posedge clk);
                #1 check("R8 irq single cycle", stop_done_irq, 1'b0);
            end
        end

        // collision abort while draining: no retry start granted
        goto_state(1);
        drive(1, 1, 0, 1, 1);
        @(posedge clk);
        drive(1, 0, 0, 0, 1);
        #1 check("R7 no retry after collision", tx_start_en, 1'b0);
        @(posedge clk);
        #1 check("R7 still blocked while halted", tx_start_en, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule